// File: doc/BRIEF.md
# Configurable Timer Counter Channel

This block is one channel of a general-purpose timer. It holds a 16-bit up-counter, four compare registers and an 8-bit control register. The control register picks what advances the counter, which transition of an external clock pin counts when that pin is the source, and what returns the counter to zero. The counter can be advanced by the system clock or by a fixed fraction of it, taken from a free-running 5-bit divider. It can also be advanced by transitions on an external pin, which is first brought into the system clock domain by a two-flop synchronizer.

The counter can be cleared when it equals one of the four compare registers. It can also be cleared together with a paired channel: the `clr_out_o` of one channel is wired to the `clr_in_i` of the other. This works only while the synchronous-operation input is high. Software writes the control and compare registers through simple write strobes, and the control value and counter are visible on output ports. Every state element runs on the single system clock.

Top module: `tmr_channel`

## Requirements
- R1: After reset `count_o` is 0, `ctrl_o` is 8'h00 and `clr_out_o` is 0. The prescaler divider and the pin synchronizer also start at 0.
- R2: Count source field `ctrl[2:0]`: codes 0, 1, 2, 3 and 4 advance the counter once every 1, 2, 4, 8 and 32 clocks. A 5-bit divider counts up every clock from 0 after reset, and divide-by-2^k fires in the cycles where its low k bits are all ones. With clear code 0 the counter wraps from 16'hFFFF to 0.
- R3: Clear field `ctrl[7:5]`: codes 1, 2, 5 and 6 clear the counter on compare register 0, 1, 2 and 3 (A, B, C, D, selected by `cmp_sel_i`). The clear happens on a counting cycle in which `count_o` equals that register. Code 0 never clears.
- R4: Count source code 5 counts transitions of `ext_clk_i` only while `ext_en_i` is 1. Edge field `ctrl[4:3]` selects the transition: 0 rising, 1 falling, 2 both. `count_o` changes on the third rising clock edge after the pin changes, so the pin change must be set up to the first of those edges.
- R5: Clear code 3 with `sync_mode_i` at 1 clears the counter on the next clock edge in any cycle where `clr_in_i` is 1, regardless of the count source. With `sync_mode_i` at 0, code 3 never clears.
- R6: `clr_out_o` is 1 exactly in a cycle where the channel's own compare clear takes effect at the next edge.
- R7: Reserved codes hold the counter with no count and no clear: clear codes 4 and 7, source codes 6 and 7, and edge code 3.
- R8: When a compare clear and a count happen in the same cycle, the counter becomes 0, not the incremented value.
- R9: While `run_i` is 0 the counter holds its value, with no count and no clear.
- R10: `ctrl_we_i` loads `ctrl_wdata_i` into the control register, and `cmp_we_i` loads `cmp_wdata_i` into the compare register chosen by `cmp_sel_i`. Both writes first act on the cycle after the write edge. `ctrl_o` shows the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counting allowed when high |
| sync_mode_i | input | 1 | Enables the paired-channel clear code |
| ext_en_i | input | 1 | Enables counting from the external pin |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_sel_i | input | 2 | Compare register select, 0..3 = A..D |
| cmp_wdata_i | input | 16 | Compare register write data |
| clr_in_i | input | 1 | Clear request from the paired channel |
| clr_out_o | output | 1 | Compare clear taking effect, to the paired channel |
| count_o | output | 16 | Counter value |
| ctrl_o | output | 8 | Control register value |

## Verification
The counter is driven with each divide setting from a known divider phase, so that a period off by one clock or a wrong bit tap shows up as a count drift. External-pin stimulus toggles slowly under each edge code and again with the pin enable low, which separates rising-only, falling-only and both-edge counting and exposes a wrong synchronizer latency. Small compare values under every clear code, with sparse pair-clear pulses, separate a clear on the right register from one on a neighbour and test clear-over-count priority. A long free-running stretch reaches the 16-bit wrap, and random phases mix in reserved codes and run gaps, which must freeze the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCMP = 4;

    typedef enum logic [2:0] {
        CLR_FREE = 3'd0,
        CLR_CMPA = 3'd1,
        CLR_CMPB = 3'd2,
        CLR_PAIR = 3'd3,
        CLR_BAD4 = 3'd4,
        CLR_CMPC = 3'd5,
        CLR_CMPD = 3'd6,
        CLR_BAD7 = 3'd7
    } clr_sel_e;

    typedef enum logic [1:0] {
        EDG_RISE = 2'd0,
        EDG_FALL = 2'd1,
        EDG_BOTH = 2'd2,
        EDG_BAD  = 2'd3
    } edge_sel_e;

    typedef enum logic [2:0] {
        SRC_D1   = 3'd0,
        SRC_D2   = 3'd1,
        SRC_D4   = 3'd2,
        SRC_D8   = 3'd3,
        SRC_D32  = 3'd4,
        SRC_PIN  = 3'd5,
        SRC_BAD6 = 3'd6,
        SRC_BAD7 = 3'd7
    } src_sel_e;

    typedef struct packed {
        clr_sel_e  clr;
        edge_sel_e edg;
        src_sel_e  src;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter  int DIV_W = 5,
    localparam int SH_W  = $clog2(DIV_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SH_W-1:0] shift_i,
    output logic            tick_o
);

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        div_d  = div_q + 1'b1;
        mask   = ~({DIV_W{1'b1}} << shift_i);
        tick_o = ((div_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_N:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[SYNC_N-1:0], pin_i};
        rise_o =  sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
        fall_o = ~sh_q[SYNC_N-1] &  sh_q[SYNC_N];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/tmr_clear_sel.sv
module tmr_clear_sel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  clr_sel_e                     code_i,
    input  logic [CNT_W-1:0]             cnt_i,
    input  logic [NCMP-1:0][CNT_W-1:0]   cmp_i,
    input  logic                         sync_mode_i,
    input  logic                         clr_in_i,
    output logic                         cmp_hit_o,
    output logic                         pair_hit_o,
    output logic                         bad_o
);

    logic [NCMP-1:0] eq;

    for (genvar g = 0; g < NCMP; g++) begin : g_eq
        assign eq[g] = (cnt_i == cmp_i[g]);
    end

    always_comb begin
        cmp_hit_o  = 1'b0;
        pair_hit_o = 1'b0;
        bad_o      = 1'b0;
        case (code_i)
            CLR_CMPA: cmp_hit_o  = eq[0];
            CLR_CMPB: cmp_hit_o  = eq[1];
            CLR_CMPC: cmp_hit_o  = eq[2];
            CLR_CMPD: cmp_hit_o  = eq[3];
            CLR_PAIR: pair_hit_o = sync_mode_i & clr_in_i;
            CLR_BAD4,
            CLR_BAD7: bad_o      = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int DIV_W  = 5,
    parameter  int SYNC_N = 2,
    localparam int SEL_W  = $clog2(NCMP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             sync_mode_i,
    input  logic             ext_en_i,
    input  logic             ext_clk_i,
    input  logic             ctrl_we_i,
    input  logic [7:0]       ctrl_wdata_i,
    input  logic             cmp_we_i,
    input  logic [SEL_W-1:0] cmp_sel_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic             clr_in_i,
    output logic             clr_out_o,
    output logic [CNT_W-1:0] count_o,
    output logic [7:0]       ctrl_o
);

    localparam int SH_W = $clog2(DIV_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0]           cnt;
        ctrl_t                      ctrl;
        logic [NCMP-1:0][CNT_W-1:0] cmp;
    } state_t;

    state_t st_d, st_q;

    logic [SH_W-1:0] shift_sel;
    logic            pre_tick;
    logic            pin_rise, pin_fall;
    logic            cmp_hit, pair_hit, clr_bad;
    logic            src_bad, edge_bad, pin_tick, tick, active;

    // divide selection for the prescaler
    always_comb begin
        case (st_q.ctrl.src)
            SRC_D2:  shift_sel = SH_W'(1);
            SRC_D4:  shift_sel = SH_W'(2);
            SRC_D8:  shift_sel = SH_W'(3);
            SRC_D32: shift_sel = SH_W'(DIV_W);
            default: shift_sel = '0;
        endcase
    end

    tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_sel),
        .tick_o  (pre_tick)
    );

    tmr_edge_det #(.SYNC_N(SYNC_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    tmr_clear_sel #(.CNT_W(CNT_W)) u_clr (
        .code_i      (st_q.ctrl.clr),
        .cnt_i       (st_q.cnt),
        .cmp_i       (st_q.cmp),
        .sync_mode_i (sync_mode_i),
        .clr_in_i    (clr_in_i),
        .cmp_hit_o   (cmp_hit),
        .pair_hit_o  (pair_hit),
        .bad_o       (clr_bad)
    );

    always_comb begin
        src_bad  = (st_q.ctrl.src == SRC_BAD6) || (st_q.ctrl.src == SRC_BAD7);
        edge_bad = (st_q.ctrl.edg == EDG_BAD);

        case (st_q.ctrl.edg)
            EDG_RISE: pin_tick = ext_en_i & pin_rise;
            EDG_FALL: pin_tick = ext_en_i & pin_fall;
            EDG_BOTH: pin_tick = ext_en_i & (pin_rise | pin_fall);
            default:  pin_tick = 1'b0;
        endcase

        tick   = (st_q.ctrl.src == SRC_PIN) ? pin_tick : pre_tick;
        active = run_i & ~(src_bad | edge_bad | clr_bad);

        st_d = st_q;
        if (ctrl_we_i) st_d.ctrl = ctrl_t'(ctrl_wdata_i);
        if (cmp_we_i)  st_d.cmp[cmp_sel_i] = cmp_wdata_i;

        if (active) begin
            if (pair_hit || (tick && cmp_hit)) st_d.cnt = '0;
            else if (tick)                     st_d.cnt = st_q.cnt + 1'b1;
        end

        clr_out_o = active & tick & cmp_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign ctrl_o  = st_q.ctrl;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             sync_mode_i,
    input logic             clr_in_i,
    input logic             ctrl_we_i,
    input logic [7:0]       ctrl_wdata_i,
    input logic             clr_out_o,
    input logic [CNT_W-1:0] count_o,
    input logic [7:0]       ctrl_o
);

    logic code_bad;
    assign code_bad = (ctrl_o[7:5] == 3'd4) || (ctrl_o[7:5] == 3'd7) ||
                      (ctrl_o[2:0] >= 3'd6) || (ctrl_o[4:3] == 2'd3);

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_o == $past(count_o)));

    // R7
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_bad |=> (count_o == $past(count_o)));

    // R6
    clr_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_out_o |=> (count_o == '0));

    // R5
    pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !code_bad && ctrl_o[7:5] == 3'd3 && sync_mode_i && clr_in_i)
        |=> (count_o == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((count_o == CNT_W'($past(count_o) + 1'b1)) ||
                  (count_o == '0) || (count_o == $past(count_o))));

    // R10
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we_i |=> (ctrl_o == $past(ctrl_wdata_i)));

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .sync_mode_i  (sync_mode_i),
    .clr_in_i     (clr_in_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .clr_out_o    (clr_out_o),
    .count_o      (count_o),
    .ctrl_o       (ctrl_o)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0, sync_mode_i = 1'b0, ext_en_i = 1'b0, ext_clk_i = 1'b0;
    logic        ctrl_we_i = 1'b0, cmp_we_i = 1'b0, clr_in_i = 1'b0;
    logic [7:0]  ctrl_wdata_i = '0;
    logic [1:0]  cmp_sel_i = '0;
    logic [15:0] cmp_wdata_i = '0;
    logic        clr_out_o;
    logic [15:0] count_o;
    logic [7:0]  ctrl_o;

    tmr_channel i_tmr_channel (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .sync_mode_i(sync_mode_i),
        .ext_en_i(ext_en_i), .ext_clk_i(ext_clk_i), .ctrl_we_i(ctrl_we_i),
        .ctrl_wdata_i(ctrl_wdata_i), .cmp_we_i(cmp_we_i), .cmp_sel_i(cmp_sel_i),
        .cmp_wdata_i(cmp_wdata_i), .clr_in_i(clr_in_i), .clr_out_o(clr_out_o),
        .count_o(count_o), .ctrl_o(ctrl_o)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // next-cycle stimulus
    logic        n_run = 0, n_sync = 0, n_een = 0, n_pin = 0, n_cwe = 0, n_mwe = 0, n_cin = 0;
    logic [7:0]  n_ctrl = 0;
    logic [1:0]  n_sel = 0;
    logic [15:0] n_cmp = 0;

    // reference model state
    logic [15:0] m_cnt;
    logic [7:0]  m_ctrl;
    logic [15:0] m_cmp [4];
    logic [4:0]  m_div;
    logic        m_p1, m_p2, m_p3;
    string       m_tag = "R1";
    logic        m_act, m_tk, m_mt, m_sc;

    function automatic logic m_rsv();
        return (m_ctrl[7:5] == 3'd4) || (m_ctrl[7:5] == 3'd7) ||
               (m_ctrl[2:0] >= 3'd6) || (m_ctrl[4:3] == 2'd3);
    endfunction

    function automatic logic m_tick(input logic en);
        logic r, f;
        r = m_p2 & ~m_p3;
        f = ~m_p2 & m_p3;
        case (m_ctrl[2:0])
            3'd0: return 1'b1;
            3'd1: return m_div[0];
            3'd2: return &m_div[1:0];
            3'd3: return &m_div[2:0];
            3'd4: return &m_div;
            3'd5: return en && ((m_ctrl[4:3] == 2'd0) ? r :
                                (m_ctrl[4:3] == 2'd1) ? f :
                                (m_ctrl[4:3] == 2'd2) ? (r | f) : 1'b0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic m_match();
        case (m_ctrl[7:5])
            3'd1: return m_cnt == m_cmp[0];
            3'd2: return m_cnt == m_cmp[1];
            3'd5: return m_cnt == m_cmp[2];
            3'd6: return m_cnt == m_cmp[3];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_div = 0;
            m_p1 = 0; m_p2 = 0; m_p3 = 0;
            for (int i = 0; i < 4; i++) m_cmp[i] = 0;
            m_tag = "R1";
        end else begin
            m_act = run_i && !m_rsv();
            m_tk  = m_tick(ext_en_i);
            m_mt  = m_match();
            m_sc  = (m_ctrl[7:5] == 3'd3) && sync_mode_i && clr_in_i;
            if (!run_i)                 m_tag = "R9";
            else if (m_rsv())           m_tag = "R7";
            else if (m_sc)              m_tag = "R5";
            else if (m_tk && m_mt)      m_tag = "R8";
            else if (m_ctrl[2:0] == 5)  m_tag = "R4";
            else if (m_ctrl[7:5] != 0)  m_tag = "R3";
            else                        m_tag = "R2";
            if (m_act) begin
                if (m_sc || (m_tk && m_mt)) m_cnt = 0;
                else if (m_tk)              m_cnt = m_cnt + 1'b1;
            end
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_clk_i;
            m_div = m_div + 1'b1;
            if (ctrl_we_i) m_ctrl = ctrl_wdata_i;
            if (cmp_we_i)  m_cmp[cmp_sel_i] = cmp_wdata_i;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle();
        logic e;
        @(negedge clk);
        chk(m_tag, {16'h0, count_o}, {16'h0, m_cnt});
        chk("R10", {24'h0, ctrl_o}, {24'h0, m_ctrl});
        run_i = n_run; sync_mode_i = n_sync; ext_en_i = n_een; ext_clk_i = n_pin;
        ctrl_we_i = n_cwe; ctrl_wdata_i = n_ctrl; cmp_we_i = n_mwe; cmp_sel_i = n_sel;
        cmp_wdata_i = n_cmp; clr_in_i = n_cin;
        #1;
        e = run_i && !m_rsv() && m_tick(ext_en_i) && m_match();
        chk("R6", {31'h0, clr_out_o}, {31'h0, e});
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        n_cwe = 1; n_ctrl = v; cycle(); n_cwe = 0;
    endtask

    task automatic wr_cmp(input logic [1:0] s, input logic [15:0] v);
        n_mwe = 1; n_sel = s; n_cmp = v; cycle(); n_mwe = 0;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] c, s;
        logic [1:0] g;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", {16'h0, count_o}, 32'h0);
        chk("R1", {24'h0, ctrl_o}, 32'h0);
        chk("R1", {31'h0, clr_out_o}, 32'h0);

        // R2 divide by 1 free run
        n_run = 1;
        run_n(12);
        // R2 other dividers
        wr_ctrl(8'h01); run_n(20);
        wr_ctrl(8'h02); run_n(20);
        wr_ctrl(8'h03); run_n(40);
        wr_ctrl(8'h04); run_n(100);

        // R3 / R8 compare clears on each register
        wr_cmp(2'd0, 16'd5); wr_cmp(2'd1, 16'd7); wr_cmp(2'd2, 16'd3); wr_cmp(2'd3, 16'd9);
        wr_ctrl(8'h21); run_n(40);
        wr_ctrl(8'h40); run_n(30);
        wr_ctrl(8'hA0); run_n(30);
        wr_ctrl(8'hC2); run_n(60);

        // R9 run low holds
        n_run = 0; run_n(15); n_run = 1;

        // R7 reserved codes
        wr_ctrl(8'h80); run_n(20);
        wr_ctrl(8'hE0); run_n(20);
        wr_ctrl(8'h06); run_n(20);
        wr_ctrl(8'h18); run_n(20);

        // R5 pair clear, with and without sync mode
        wr_ctrl(8'h60);
        n_sync = 1; run_n(10); n_cin = 1; cycle(); n_cin = 0; run_n(10);
        n_sync = 0; n_cin = 1; run_n(3); n_cin = 0; run_n(5);

        // R4 external pin, each edge code and enable off
        foreach (n_ctrl[i]) ;
        for (int e = 0; e < 3; e++) begin
            wr_ctrl({3'd0, 2'(e), 3'd5});
            n_een = 1;
            for (int k = 0; k < 10; k++) begin n_pin = ~n_pin; run_n(4); end
        end
        n_een = 0;
        for (int k = 0; k < 6; k++) begin n_pin = ~n_pin; run_n(4); end

        // R2 wrap at full scale
        wr_ctrl(8'h00);
        run_n(65600);

        // random phases
        for (int p = 0; p < 40; p++) begin
            c = 3'($urandom % 7); if (c == 3'd4 && ($urandom % 3) != 0) c = 3'd1;
            s = 3'($urandom % 6); if (($urandom % 10) == 0) s = 3'd6;
            g = 2'($urandom % 3); if (($urandom % 12) == 0) g = 2'd3;
            for (int r = 0; r < 4; r++) wr_cmp(2'(r), 16'($urandom % 48));
            n_sync = 1'($urandom % 2);
            n_een  = (($urandom % 4) != 0);
            wr_ctrl({c, g, s});
            for (int k = 0; k < 300; k++) begin
                if (($urandom % 3) == 0) n_pin = ~n_pin;
                n_cin = (($urandom % 20) == 0);
                n_run = (($urandom % 16) != 0);
                cycle();
            end
            n_cin = 0; n_run = 1;
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule